// File: doc/BRIEF.md
# Network Input Stall Watchdog with Interrupt Stripping and Replay Substitution

This block sits between the head of a network input FIFO and the register-mapped read port of a processor pipeline. A processor read takes the head word in the same cycle when one is present, and stalls when the input is empty. Three services are added on that path. A watchdog counts how long a word has waited at the head unread and raises a deadlock interrupt once a programmable limit is passed, so that software can drain the network into memory. A reserved one-word interrupt message is recognised at the head, removed without the processor ever seeing it, and latched into an external-interrupt bit. After a drain, a replay mode lets software feed the drained words back through the same read port, while live network words stay buffered until the mode is left.

Two state machines carry the behaviour. The source machine has the states SRC_LIVE (reads come from the network; stripping and timing are active) and SRC_REPLAY (reads come from the replay stream; the network is neither popped nor timed). Its transitions are enter (SRC_LIVE to SRC_REPLAY on `mode_enter`) and leave (SRC_REPLAY to SRC_LIVE on `mode_leave`), with leave taking priority. The watchdog machine has the states WD_IDLE (no word waiting), WD_COUNT (a word is waiting and the counter runs) and WD_FIRED (the interrupt has been raised for the current word). Its transitions are arm (WD_IDLE to WD_COUNT when a word waits and the watchdog is enabled), fire (WD_COUNT to WD_FIRED when the limit is passed), release (WD_COUNT or WD_FIRED to WD_IDLE when the head is consumed, the input empties, or the watchdog is disabled).

Top module: `netin_guard`

## Requirements
- R1: After reset `ext_irq`, `dl_irq` and `in_replay` are 0, the watchdog is disabled (enable 0, limit 0) and the reserved interrupt value is `TAG_RESET` (default 32'hFFFF_FFF0).
- R2: In live mode, when `net_valid` is 1 and `net_data` differs from the reserved value, `cpu_valid` is 1 and `cpu_data` equals `net_data` in the same cycle; `net_pop` is 1 exactly when `cpu_rd` is also 1.
- R3: When `cpu_rd` is 1 and no deliverable word is present, `cpu_stall` is 1 and `cpu_valid` is 0; no word is delivered.
- R4: In live mode a head word equal to the reserved value is popped in the same cycle whether or not `cpu_rd` is 1, `cpu_valid` stays 0 for it, and `ext_irq` is 1 after the next clock edge.
- R5: `ext_irq` stays 1 until a cycle with `ext_clr` 1; if a reserved word is stripped in that same cycle, `ext_irq` stays 1.
- R6: A cycle with `tag_we` 1 loads `tag_in` as the reserved value; the old value then passes as ordinary data.
- R7: With enable 1 and limit L > 0 (written with `cfg_we`), a live head word left unread for L consecutive clock edges leaves `dl_irq` at 0, and `dl_irq` is 1 after the L+1-th such edge.
- R8: The wait count restarts whenever the head word is consumed or the input is empty, so no run of waiting shorter than L+1 edges raises `dl_irq`.
- R9: A limit of 0 or an enable of 0 disables the watchdog: `dl_irq` never rises.
- R10: `dl_irq` stays 1 until a cycle with `dl_clr` 1; after clearing, it does not rise again for the same still-waiting head word.
- R11: In replay mode `cpu_valid` follows `rpl_valid`, `cpu_data` equals `rpl_data`, `rpl_pop` equals `cpu_rd && rpl_valid`, `net_pop` is 0 (reserved words included) and the watchdog does not count.
- R12: After leaving replay mode, reads return the buffered network head word.
- R13: When `mode_enter` and `mode_leave` are both 1, the block is in live mode after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_valid | input | 1 | Network FIFO head holds a word |
| net_data | input | DATA_W | Network FIFO head word |
| net_pop | output | 1 | Consume the network head word this cycle |
| rpl_valid | input | 1 | Replay stream holds a word |
| rpl_data | input | DATA_W | Replay stream head word |
| rpl_pop | output | 1 | Consume the replay head word this cycle |
| cpu_rd | input | 1 | Processor reads the input port this cycle |
| cpu_valid | output | 1 | A deliverable word is present |
| cpu_data | output | DATA_W | Word delivered to the processor |
| cpu_stall | output | 1 | Read requested with nothing to deliver |
| cfg_we | input | 1 | Write watchdog enable and limit |
| cfg_en | input | 1 | Watchdog enable value to write |
| cfg_limit | input | CNT_W | Watchdog limit value to write |
| tag_we | input | 1 | Write reserved interrupt value |
| tag_in | input | DATA_W | Reserved interrupt value to write |
| mode_enter | input | 1 | Enter replay mode |
| mode_leave | input | 1 | Leave replay mode |
| in_replay | output | 1 | Block is in replay mode |
| ext_clr | input | 1 | Clear the external-interrupt bit |
| ext_irq | output | 1 | External interrupt from a stripped message |
| dl_clr | input | 1 | Clear the deadlock interrupt |
| dl_irq | output | 1 | Deadlock (stall timeout) interrupt |

## Verification
The assertions watch, on every cycle, that no pop reaches the idle source, that neither the network nor the replay stream is popped without a word present, that a reserved word is never delivered, that both interrupt bits hold until cleared, and that a deadlock interrupt only ever rises after a cycle with an armed watchdog and an unread live word. Exact timing of the watchdog at the L and L+1 edges, the restart of the count after a consumption, the no-refire rule after a clear, word order across a replay episode and the set-wins-over-clear rule on the external bit can only be shown by the bench's scenarios.

// File: rtl/nig_pkg.sv
package nig_pkg;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_REPLAY = 1'b1
    } src_state_e;

    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_COUNT = 2'd1,
        WD_FIRED = 2'd2
    } wd_state_e;

endpackage

// File: rtl/nig_regs.sv
// Software-visible configuration and the two sticky interrupt bits.
module nig_regs #(
    parameter int unsigned          DATA_W    = 32,
    parameter int unsigned          CNT_W     = 16,
    parameter logic [DATA_W-1:0]    TAG_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_en,
    input  logic [CNT_W-1:0]  cfg_limit,
    input  logic              tag_we,
    input  logic [DATA_W-1:0] tag_in,
    input  logic              strip_evt,
    input  logic              ext_clr,
    input  logic              fire_evt,
    input  logic              dl_clr,
    output logic              wd_en,
    output logic [CNT_W-1:0]  wd_limit,
    output logic [DATA_W-1:0] tag_q,
    output logic              ext_irq,
    output logic              dl_irq
);

    // R1 reset values, R6 tag load, R7/R9 limit and enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_en    <= 1'b0;
            wd_limit <= '0;
            tag_q    <= TAG_RESET;
        end else begin
            if (cfg_we) begin
                wd_en    <= cfg_en;
                wd_limit <= cfg_limit;
            end
            if (tag_we) begin
                tag_q <= tag_in;
            end
        end
    end

    // R5 and R10: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_irq <= 1'b0;
            dl_irq  <= 1'b0;
        end else begin
            if (strip_evt) begin
                ext_irq <= 1'b1;
            end else if (ext_clr) begin
                ext_irq <= 1'b0;
            end
            if (fire_evt) begin
                dl_irq <= 1'b1;
            end else if (dl_clr) begin
                dl_irq <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/nig_source.sv
// Source selection state machine, read port and reserved-word stripping.
module nig_source
    import nig_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_enter,
    input  logic              mode_leave,
    input  logic              net_valid,
    input  logic [DATA_W-1:0] net_data,
    input  logic              rpl_valid,
    input  logic [DATA_W-1:0] rpl_data,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] tag_q,
    output logic              net_pop,
    output logic              rpl_pop,
    output logic              cpu_valid,
    output logic [DATA_W-1:0] cpu_data,
    output logic              cpu_stall,
    output logic              in_replay,
    output logic              strip_evt,
    output logic              live_wait
);

    src_state_e state_q, state_d;
    logic       head_is_tag;

    assign head_is_tag = net_valid && (net_data == tag_q);

    // next-state logic; R13: leave wins over enter
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_LIVE: begin
                if (mode_enter && !mode_leave) begin
                    state_d = SRC_REPLAY;
                end
            end
            SRC_REPLAY: begin
                if (mode_leave) begin
                    state_d = SRC_LIVE;
                end
            end
            default: state_d = SRC_LIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRC_LIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs: R2, R3, R4, R11
    always_comb begin
        net_pop   = 1'b0;
        rpl_pop   = 1'b0;
        cpu_valid = 1'b0;
        cpu_data  = net_data;
        strip_evt = 1'b0;
        live_wait = 1'b0;
        in_replay = 1'b0;
        unique case (state_q)
            SRC_LIVE: begin
                strip_evt = head_is_tag;
                cpu_valid = net_valid && !head_is_tag;
                net_pop   = head_is_tag || (cpu_valid && cpu_rd);
                live_wait = cpu_valid && !cpu_rd;
            end
            SRC_REPLAY: begin
                in_replay = 1'b1;
                cpu_valid = rpl_valid;
                cpu_data  = rpl_data;
                rpl_pop   = rpl_valid && cpu_rd;
            end
            default: begin
                cpu_valid = 1'b0;
            end
        endcase
        cpu_stall = cpu_rd && !cpu_valid;
    end

endmodule

// File: rtl/nig_wdog.sv
// Head-of-line wait timer state machine.
module nig_wdog
    import nig_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wait_i,
    input  logic             wd_en,
    input  logic [CNT_W-1:0] wd_limit,
    output logic             fire
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             armed;

    assign armed = wd_en && (wd_limit != '0);   // R9

    // next state and count; R7, R8, R10
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WD_IDLE: begin
                cnt_d = '0;
                if (wait_i && armed) begin
                    state_d = WD_COUNT;
                    cnt_d   = CNT_ONE;
                end
            end
            WD_COUNT: begin
                if (!wait_i || !armed) begin
                    state_d = WD_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q >= wd_limit) begin
                    state_d = WD_FIRED;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
            WD_FIRED: begin
                if (!wait_i || !armed) begin
                    state_d = WD_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = WD_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output: one-cycle fire pulse on the fire transition
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            WD_COUNT: fire = wait_i && armed && (cnt_q >= wd_limit);
            WD_IDLE:  fire = 1'b0;
            WD_FIRED: fire = 1'b0;
            default:  fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/netin_guard.sv
module netin_guard #(
    parameter int unsigned       DATA_W    = 32,
    parameter int unsigned       CNT_W     = 16,
    parameter logic [DATA_W-1:0] TAG_RESET = 32'hFFFF_FFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              net_valid,
    input  logic [DATA_W-1:0] net_data,
    output logic              net_pop,
    input  logic              rpl_valid,
    input  logic [DATA_W-1:0] rpl_data,
    output logic              rpl_pop,
    input  logic              cpu_rd,
    output logic              cpu_valid,
    output logic [DATA_W-1:0] cpu_data,
    output logic              cpu_stall,
    input  logic              cfg_we,
    input  logic              cfg_en,
    input  logic [CNT_W-1:0]  cfg_limit,
    input  logic              tag_we,
    input  logic [DATA_W-1:0] tag_in,
    input  logic              mode_enter,
    input  logic              mode_leave,
    output logic              in_replay,
    input  logic              ext_clr,
    output logic              ext_irq,
    input  logic              dl_clr,
    output logic              dl_irq
);

    logic              wd_en;
    logic [CNT_W-1:0]  wd_limit;
    logic [DATA_W-1:0] tag_q;
    logic              strip_evt;
    logic              live_wait;
    logic              fire_evt;

    nig_regs #(
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .TAG_RESET (TAG_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_en    (cfg_en),
        .cfg_limit (cfg_limit),
        .tag_we    (tag_we),
        .tag_in    (tag_in),
        .strip_evt (strip_evt),
        .ext_clr   (ext_clr),
        .fire_evt  (fire_evt),
        .dl_clr    (dl_clr),
        .wd_en     (wd_en),
        .wd_limit  (wd_limit),
        .tag_q     (tag_q),
        .ext_irq   (ext_irq),
        .dl_irq    (dl_irq)
    );

    nig_source #(
        .DATA_W (DATA_W)
    ) u_source (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_enter (mode_enter),
        .mode_leave (mode_leave),
        .net_valid  (net_valid),
        .net_data   (net_data),
        .rpl_valid  (rpl_valid),
        .rpl_data   (rpl_data),
        .cpu_rd     (cpu_rd),
        .tag_q      (tag_q),
        .net_pop    (net_pop),
        .rpl_pop    (rpl_pop),
        .cpu_valid  (cpu_valid),
        .cpu_data   (cpu_data),
        .cpu_stall  (cpu_stall),
        .in_replay  (in_replay),
        .strip_evt  (strip_evt),
        .live_wait  (live_wait)
    );

    nig_wdog #(
        .CNT_W (CNT_W)
    ) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_i   (live_wait),
        .wd_en    (wd_en),
        .wd_limit (wd_limit),
        .fire     (fire_evt)
    );

endmodule

// File: rtl/nig_checker.sv
module nig_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              net_valid,
    input logic [DATA_W-1:0] net_data,
    input logic              net_pop,
    input logic              rpl_valid,
    input logic              rpl_pop,
    input logic              cpu_valid,
    input logic [DATA_W-1:0] cpu_data,
    input logic              in_replay,
    input logic [DATA_W-1:0] tag_q,
    input logic              wd_en,
    input logic [CNT_W-1:0]  wd_limit,
    input logic              ext_clr,
    input logic              ext_irq,
    input logic              dl_clr,
    input logic              dl_irq
);

    // R2: the network is only popped when it holds a word
    a_r2_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        net_pop |-> net_valid);

    // R4: a reserved word is never delivered from the live source
    a_r4_no_tag_delivered: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !in_replay) |-> (cpu_data != tag_q));

    // R5: external interrupt bit is sticky
    a_r5_ext_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_irq && !ext_clr) |=> ext_irq);

    // R7: deadlock interrupt rises only after an armed live wait
    a_r7_dl_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dl_irq) |-> $past(net_valid && !net_pop && !in_replay));

    // R9: a disabled watchdog never fires
    a_r9_dl_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dl_irq) |-> $past(wd_en && (wd_limit != '0)));

    // R10: deadlock interrupt is sticky
    a_r10_dl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (dl_irq && !dl_clr) |=> dl_irq);

    // R11: no network pop in replay, no replay pop in live mode
    a_r11_src_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (in_replay |-> !net_pop) and (!in_replay |-> !rpl_pop));

    a_r11_rpl_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        rpl_pop |-> rpl_valid);

endmodule

bind netin_guard nig_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_nig_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .net_valid (net_valid),
    .net_data  (net_data),
    .net_pop   (net_pop),
    .rpl_valid (rpl_valid),
    .rpl_pop   (rpl_pop),
    .cpu_valid (cpu_valid),
    .cpu_data  (cpu_data),
    .in_replay (in_replay),
    .tag_q     (tag_q),
    .wd_en     (wd_en),
    .wd_limit  (wd_limit),
    .ext_clr   (ext_clr),
    .ext_irq   (ext_irq),
    .dl_clr    (dl_clr),
    .dl_irq    (dl_irq)
);

// File: tb/netin_guard_bench.sv
`timescale 1ns/1ps
module netin_guard_bench;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned CNT_W  = 16;
    localparam logic [31:0] TAG0   = 32'hFFFF_FFF0;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              net_valid, rpl_valid, cpu_rd;
    logic [DATA_W-1:0] net_data, rpl_data, tag_in;
    logic              net_pop, rpl_pop, cpu_valid, cpu_stall;
    logic [DATA_W-1:0] cpu_data;
    logic              cfg_we, cfg_en, tag_we;
    logic [CNT_W-1:0]  cfg_limit;
    logic              mode_enter, mode_leave, in_replay;
    logic              ext_clr, ext_irq, dl_clr, dl_irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    netin_guard #(.DATA_W(DATA_W), .CNT_W(CNT_W), .TAG_RESET(TAG0)) u_netin_guard (
        .clk(clk), .rst_n(rst_n),
        .net_valid(net_valid), .net_data(net_data), .net_pop(net_pop),
        .rpl_valid(rpl_valid), .rpl_data(rpl_data), .rpl_pop(rpl_pop),
        .cpu_rd(cpu_rd), .cpu_valid(cpu_valid), .cpu_data(cpu_data), .cpu_stall(cpu_stall),
        .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_limit(cfg_limit),
        .tag_we(tag_we), .tag_in(tag_in),
        .mode_enter(mode_enter), .mode_leave(mode_leave), .in_replay(in_replay),
        .ext_clr(ext_clr), .ext_irq(ext_irq), .dl_clr(dl_clr), .dl_irq(dl_irq)
    );

    typedef struct packed {
        logic        nv;
        logic [31:0] nd;
        logic        rd;
        logic        e_valid;
        logic        e_pop;
        logic        e_stall;
    } vec_t;

    // live-mode read port vectors (R2, R3, R4)
    localparam vec_t VEC [6] = '{
        '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b1},
        '{1'b1, 32'h0000_0011, 1'b1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 32'h0000_0022, 1'b0, 1'b1, 1'b0, 1'b0},
        '{1'b1, TAG0,          1'b0, 1'b0, 1'b1, 1'b0},
        '{1'b1, TAG0,          1'b1, 1'b0, 1'b1, 1'b1},
        '{1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_cfg(input logic en, input logic [CNT_W-1:0] lim);
        cfg_we = 1'b1; cfg_en = en; cfg_limit = lim;
        step();
        cfg_we = 1'b0;
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; net_valid = 0; net_data = '0; rpl_valid = 0; rpl_data = '0;
        cpu_rd = 0; cfg_we = 0; cfg_en = 0; cfg_limit = '0; tag_we = 0; tag_in = '0;
        mode_enter = 0; mode_leave = 0; ext_clr = 0; dl_clr = 0;
        steps(3);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 ext_irq", 32'(ext_irq), 0);
        chk("R1 dl_irq", 32'(dl_irq), 0);
        chk("R1 in_replay", 32'(in_replay), 0);
        step();

        // table walk
        for (int i = 0; i < 6; i++) begin
            net_valid = VEC[i].nv; net_data = VEC[i].nd; cpu_rd = VEC[i].rd;
            #1;
            chk("R2/R4 cpu_valid", 32'(cpu_valid), 32'(VEC[i].e_valid));
            chk("R2/R4 net_pop", 32'(net_pop), 32'(VEC[i].e_pop));
            chk("R3 cpu_stall", 32'(cpu_stall), 32'(VEC[i].e_stall));
            if (VEC[i].e_valid) chk("R2 cpu_data", cpu_data, VEC[i].nd);
            step();
        end
        chk("R4 ext_irq after strip", 32'(ext_irq), 1);

        // R5 clear, then set wins over clear
        ext_clr = 1; step(); ext_clr = 0;
        chk("R5 ext_irq cleared", 32'(ext_irq), 0);
        net_valid = 1; net_data = TAG0; ext_clr = 1; step();
        ext_clr = 0; net_valid = 0;
        chk("R5 set wins over clear", 32'(ext_irq), 1);
        ext_clr = 1; step(); ext_clr = 0;

        // R6 new reserved value
        tag_we = 1; tag_in = 32'h0000_ABCD; step(); tag_we = 0;
        net_valid = 1; net_data = TAG0; cpu_rd = 1; #1;
        chk("R6 old tag passes", 32'(cpu_valid), 1);
        net_data = 32'h0000_ABCD; #1;
        chk("R6 new tag stripped", 32'(cpu_valid), 0);
        step(); cpu_rd = 0; net_valid = 0;
        chk("R6 ext_irq from new tag", 32'(ext_irq), 1);

        // R7 watchdog timing, limit 3
        set_cfg(1'b1, 16'd3);
        net_valid = 1; net_data = 32'h0000_0005;
        steps(3);
        chk("R7 no irq after L edges", 32'(dl_irq), 0);
        step();
        chk("R7 irq after L+1 edges", 32'(dl_irq), 1);

        // R10 clear and no refire for same word
        dl_clr = 1; step(); dl_clr = 0;
        chk("R10 dl cleared", 32'(dl_irq), 0);
        steps(8);
        chk("R10 no refire same word", 32'(dl_irq), 0);
        cpu_rd = 1; step(); cpu_rd = 0;

        // R8 restart on consumption and on empty
        steps(3);
        cpu_rd = 1; step(); cpu_rd = 0;
        steps(3);
        net_valid = 0; step(); net_valid = 1;
        steps(3);
        chk("R8 restart keeps irq low", 32'(dl_irq), 0);
        net_valid = 0; step();

        // R9 disabled by zero limit and by enable 0
        set_cfg(1'b1, 16'd0);
        net_valid = 1; steps(10);
        chk("R9 limit zero", 32'(dl_irq), 0);
        set_cfg(1'b0, 16'd3);
        steps(10);
        chk("R9 enable zero", 32'(dl_irq), 0);
        set_cfg(1'b1, 16'd3);

        // R11 replay mode
        net_data = 32'h0000_0055;
        mode_enter = 1; step(); mode_enter = 0;
        chk("R11 in_replay", 32'(in_replay), 1);
        rpl_valid = 1; rpl_data = 32'h0000_0077; cpu_rd = 1; #1;
        chk("R11 cpu_data from replay", cpu_data, 32'h0000_0077);
        chk("R11 rpl_pop", 32'(rpl_pop), 1);
        chk("R11 net_pop held", 32'(net_pop), 0);
        net_data = 32'h0000_ABCD; #1;
        chk("R11 tag not stripped in replay", 32'(net_pop), 0);
        net_data = 32'h0000_0055;
        cpu_rd = 0; rpl_valid = 0; #1;
        chk("R3 replay empty stall off", 32'(cpu_stall), 0);
        steps(10);
        chk("R11 no counting in replay", 32'(dl_irq), 0);

        // R12 leave resumes network head
        mode_leave = 1; step(); mode_leave = 0;
        cpu_rd = 1; #1;
        chk("R12 live again", 32'(in_replay), 0);
        chk("R12 buffered word", cpu_data, 32'h0000_0055);
        chk("R12 net_pop", 32'(net_pop), 1);
        step(); cpu_rd = 0; net_valid = 0;

        // R13 leave wins over enter
        mode_enter = 1; mode_leave = 1; step();
        chk("R13 both from live", 32'(in_replay), 0);
        mode_leave = 0; step();
        mode_leave = 1; step();
        mode_enter = 0; mode_leave = 0;
        chk("R13 both from replay", 32'(in_replay), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule